// File: doc/BRIEF.md
# Register Rename Controller with Separate Rename File

This block sits in a single-issue decode stage. It gives each instruction's
destination a short-lived rename register. For each source it returns either a
finished value or a tag to wait on. Two storage arrays are kept. The first is
the architected register file, which holds a busy flag and a map entry per
register. The second is a smaller pool of rename registers, each holding data,
a produced flag, an in-use flag and the index of the architected register it
stands in for. Any rename register may stand in for any architected register.

Results arrive in two steps. When an instruction finishes execution, its result
lands in its rename register. When the instruction later completes, that value
is copied into the architected register and the rename register goes back to
the free pool. A source operand resolves in one of three ways:
- from the architected file when no write to that register is pending;
- from the rename register when the pending result has already been produced;
- otherwise as a tag marked not ready.

Top module: `regrename_core`

## Requirements
- R1: After reset every architected register reads as ready with value 0, no rename register is in use, and a first allocation returns tag 0 with `dec_stall` low.
- R2: A source whose architected register has no pending write reads as ready with the architected register's current value.
- R3: A source whose architected register is pending, and whose mapped rename register holds a produced result, reads as ready with that result.
- R4: A source whose architected register is pending, and whose mapped rename register has no result yet, reads as not ready, with `opnd_tag` equal to the mapped rename index.
- R5: A decode with `dec_valid` and `dec_wr` high takes the lowest-numbered free rename register and presents its index on `dec_dst_tag` in the same cycle. From the next cycle, sources naming the destination register resolve through that tag.
- R6: A finish (`fin_valid`) writes `fin_data` into rename register `fin_tag` and marks its result as produced.
- R7: A completion (`cmp_valid`) copies rename register `cmp_tag` into the architected register it stands for. That rename register is then free and may be taken again by a later allocation.
- R8: A completion clears the architected busy flag only if that register's map entry still holds the completing tag. Otherwise the younger rename stays pending.
- R9: When every rename register is in use, a decode that needs a destination raises `dec_stall` in that cycle, and no allocation or map change takes place.
- R10: Within one decode, the sources are resolved against the state before that decode's own destination is allocated.
- R11: A finish whose tag matches a source's mapped rename register in the same cycle is forwarded to that source, which reads as ready with `fin_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | An instruction is present at decode |
| dec_src | input | SRC_PORTS x AW | Architected index of each source |
| dec_wr | input | 1 | The instruction writes a destination |
| dec_dst | input | AW | Architected destination index |
| dec_stall | output | 1 | No free rename register; destination not allocated |
| dec_dst_tag | output | TW | Rename register given to the destination |
| opnd_ready | output | SRC_PORTS | Per source: value is available |
| opnd_value | output | SRC_PORTS x DATA_W | Per source: operand value when ready |
| opnd_tag | output | SRC_PORTS x TW | Per source: rename tag to wait on when not ready |
| fin_valid | input | 1 | A result has been produced |
| fin_tag | input | TW | Rename register receiving the result |
| fin_data | input | DATA_W | Result value |
| cmp_valid | input | 1 | An instruction completes |
| cmp_tag | input | TW | Rename register being retired |

## Verification
The bench overrides the defaults with eight architected registers, four rename registers and 16-bit data. The small pool fills after four back-to-back allocations, so the full-pool stall and the reuse of a freed tag come within a few cycles. With eight architected registers, each scenario can keep distinct registers apart while also aiming two renames at the same register. That brings the stale-tag completion case into reach, along with the same-cycle forwarding and the source-equals-destination ordering.

// File: rtl/regren_pkg.sv
// Shared types for the register rename controller.
// Assumes: nothing beyond standard SystemVerilog.
package regren_pkg;

    // Where a source operand is taken from
    typedef enum logic [1:0] {
        SRC_FROM_ARCH   = 2'd0,
        SRC_FROM_RENAME = 2'd1,
        SRC_PENDING     = 2'd2
    } src_origin_e;

endpackage

// File: rtl/regren_free_pick.sv
// Chooses the lowest-numbered rename register whose in-use flag is clear.
// Assumes: grant is meaningful only while any_free is high.
module regren_free_pick #(
    parameter int REN_REGS = 8,
    localparam int TW = $clog2(REN_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REN_REGS-1:0] busy_vec,
    output logic                any_free,
    output logic [TW-1:0]       grant
);

    // Priority search: the lowest free index wins
    always_comb begin
        grant = '0;
        for (int i = REN_REGS - 1; i >= 0; i--) begin
            if (!busy_vec[i]) grant = TW'(i);
        end
    end

    // Any clear in-use flag means allocation is possible
    assign any_free = ~&busy_vec;

    // R5
    free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_free |-> !busy_vec[grant]);

endmodule

// File: rtl/regren_arch_file.sv
// Architected register file with a busy flag and a rename map per register.
// Completion writes data and clears busy only on a matching map entry;
// allocation in the same cycle to the same register takes precedence.
// Assumes: the caller allocates only when a free rename register exists.
module regren_arch_file #(
    parameter int ARCH_REGS = 16,
    parameter int REN_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int SRC_PORTS = 2,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(REN_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SRC_PORTS-1:0][AW-1:0]     rd_idx,
    output logic [SRC_PORTS-1:0]             rd_busy,
    output logic [SRC_PORTS-1:0][DATA_W-1:0] rd_data,
    output logic [SRC_PORTS-1:0][TW-1:0]     rd_map,
    input  logic                             alloc_en,
    input  logic [AW-1:0]                    alloc_arch,
    input  logic [TW-1:0]                    alloc_tag,
    input  logic                             cmp_en,
    input  logic [AW-1:0]                    cmp_arch,
    input  logic [TW-1:0]                    cmp_tag,
    input  logic [DATA_W-1:0]                cmp_data
);

    logic [DATA_W-1:0]    data_q [ARCH_REGS];
    logic [TW-1:0]        map_q  [ARCH_REGS];
    logic [ARCH_REGS-1:0] busy_q;

    // State update: completion first, allocation last so it wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            for (int i = 0; i < ARCH_REGS; i++) begin
                data_q[i] <= '0;
                map_q[i]  <= '0;
            end
        end else begin
            if (cmp_en) begin
                data_q[cmp_arch] <= cmp_data;
                if (map_q[cmp_arch] == cmp_tag) busy_q[cmp_arch] <= 1'b0;
            end
            if (alloc_en) begin
                busy_q[alloc_arch] <= 1'b1;
                map_q[alloc_arch]  <= alloc_tag;
            end
        end
    end

    // Read ports, one per source
    for (genvar s = 0; s < SRC_PORTS; s++) begin : g_rd
        // Present the current entry for source s
        always_comb begin
            rd_busy[s] = busy_q[rd_idx[s]];
            rd_data[s] = data_q[rd_idx[s]];
            rd_map[s]  = map_q[rd_idx[s]];
        end
    end

    // R8
    stale_cmp_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && map_q[cmp_arch] != cmp_tag && !(alloc_en && alloc_arch == cmp_arch))
        |=> busy_q[$past(cmp_arch)] == $past(busy_q[cmp_arch]));

    // R8
    match_cmp_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && map_q[cmp_arch] == cmp_tag && !(alloc_en && alloc_arch == cmp_arch))
        |=> !busy_q[$past(cmp_arch)]);

    // R5
    alloc_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> busy_q[$past(alloc_arch)] && map_q[$past(alloc_arch)] == $past(alloc_tag));

endmodule

// File: rtl/regren_ren_file.sv
// Rename register pool: data, produced flag, in-use flag and home register.
// Finish writes a result; completion frees the entry; allocation claims it.
// A same-cycle finish is forwarded to the read ports and to the copy-out.
// Assumes: finish and completion name entries that are in use.
module regren_ren_file #(
    parameter int ARCH_REGS = 16,
    parameter int REN_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int SRC_PORTS = 2,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(REN_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [SRC_PORTS-1:0][TW-1:0]     rd_tag,
    output logic [SRC_PORTS-1:0]             rd_valid,
    output logic [SRC_PORTS-1:0][DATA_W-1:0] rd_data,
    input  logic                             alloc_en,
    input  logic [TW-1:0]                    alloc_tag,
    input  logic [AW-1:0]                    alloc_arch,
    input  logic                             fin_en,
    input  logic [TW-1:0]                    fin_tag,
    input  logic [DATA_W-1:0]                fin_data,
    input  logic                             cmp_en,
    input  logic [TW-1:0]                    cmp_tag,
    output logic [AW-1:0]                    cmp_arch,
    output logic [DATA_W-1:0]                cmp_data,
    output logic [REN_REGS-1:0]              busy_vec
);

    logic [DATA_W-1:0]   data_q [REN_REGS];
    logic [AW-1:0]       home_q [REN_REGS];
    logic [REN_REGS-1:0] valid_q;
    logic [REN_REGS-1:0] busy_q;

    // State update: finish, then completion, then allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            busy_q  <= '0;
            for (int i = 0; i < REN_REGS; i++) begin
                data_q[i] <= '0;
                home_q[i] <= '0;
            end
        end else begin
            if (fin_en) begin
                data_q[fin_tag]  <= fin_data;
                valid_q[fin_tag] <= 1'b1;
            end
            if (cmp_en) begin
                busy_q[cmp_tag]  <= 1'b0;
                valid_q[cmp_tag] <= 1'b0;
            end
            if (alloc_en) begin
                busy_q[alloc_tag]  <= 1'b1;
                valid_q[alloc_tag] <= 1'b0;
                home_q[alloc_tag]  <= alloc_arch;
            end
        end
    end

    // Read ports with forwarding of a same-cycle finish
    for (genvar s = 0; s < SRC_PORTS; s++) begin : g_rd
        logic hit;
        // Forward when the finish targets the entry being read
        always_comb begin
            hit         = fin_en && (fin_tag == rd_tag[s]);
            rd_valid[s] = valid_q[rd_tag[s]] | hit;
            rd_data[s]  = hit ? fin_data : data_q[rd_tag[s]];
        end
    end

    // Copy-out for completion, forwarding a same-cycle finish
    always_comb begin
        cmp_arch = home_q[cmp_tag];
        cmp_data = (fin_en && fin_tag == cmp_tag) ? fin_data : data_q[cmp_tag];
    end

    assign busy_vec = busy_q;

    // R6
    fin_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_en && !(cmp_en && cmp_tag == fin_tag) && !(alloc_en && alloc_tag == fin_tag))
        |=> valid_q[$past(fin_tag)] && data_q[$past(fin_tag)] == $past(fin_data));

    // R7
    cmp_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !(alloc_en && alloc_tag == cmp_tag)) |=> !busy_q[$past(cmp_tag)]);

    // R5
    alloc_claims_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> busy_q[$past(alloc_tag)] && !valid_q[$past(alloc_tag)]);

endmodule

// File: rtl/regrename_core.sv
// Register rename controller for one decode slot. Resolves each source
// from the architected file, the rename pool or as a pending tag, allocates
// a rename register for the destination, and routes finish and completion.
// Assumes: completions and finishes name rename registers that are in use.
module regrename_core #(
    parameter int ARCH_REGS = 16,
    parameter int REN_REGS  = 8,
    parameter int DATA_W    = 32,
    parameter int SRC_PORTS = 2,
    localparam int AW = $clog2(ARCH_REGS),
    localparam int TW = $clog2(REN_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             dec_valid,
    input  logic [SRC_PORTS-1:0][AW-1:0]     dec_src,
    input  logic                             dec_wr,
    input  logic [AW-1:0]                    dec_dst,
    output logic                             dec_stall,
    output logic [TW-1:0]                    dec_dst_tag,
    output logic [SRC_PORTS-1:0]             opnd_ready,
    output logic [SRC_PORTS-1:0][DATA_W-1:0] opnd_value,
    output logic [SRC_PORTS-1:0][TW-1:0]     opnd_tag,
    input  logic                             fin_valid,
    input  logic [TW-1:0]                    fin_tag,
    input  logic [DATA_W-1:0]                fin_data,
    input  logic                             cmp_valid,
    input  logic [TW-1:0]                    cmp_tag
);
    import regren_pkg::*;

    logic [SRC_PORTS-1:0]             a_busy;
    logic [SRC_PORTS-1:0][DATA_W-1:0] a_data;
    logic [SRC_PORTS-1:0][TW-1:0]     a_map;
    logic [SRC_PORTS-1:0]             r_valid;
    logic [SRC_PORTS-1:0][DATA_W-1:0] r_data;
    logic [REN_REGS-1:0]              busy_vec;
    logic                             any_free;
    logic [TW-1:0]                    grant;
    logic                             alloc_en;
    logic [AW-1:0]                    cmp_arch;
    logic [DATA_W-1:0]                cmp_data;

    // Allocation request and stall decision
    always_comb begin
        alloc_en    = dec_valid && dec_wr && any_free;
        dec_stall   = dec_valid && dec_wr && !any_free;
        dec_dst_tag = grant;
    end

    regren_free_pick #(.REN_REGS(REN_REGS)) i_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_vec (busy_vec),
        .any_free (any_free),
        .grant    (grant)
    );

    regren_arch_file #(
        .ARCH_REGS (ARCH_REGS),
        .REN_REGS  (REN_REGS),
        .DATA_W    (DATA_W),
        .SRC_PORTS (SRC_PORTS)
    ) i_arch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (dec_src),
        .rd_busy    (a_busy),
        .rd_data    (a_data),
        .rd_map     (a_map),
        .alloc_en   (alloc_en),
        .alloc_arch (dec_dst),
        .alloc_tag  (grant),
        .cmp_en     (cmp_valid),
        .cmp_arch   (cmp_arch),
        .cmp_tag    (cmp_tag),
        .cmp_data   (cmp_data)
    );

    regren_ren_file #(
        .ARCH_REGS (ARCH_REGS),
        .REN_REGS  (REN_REGS),
        .DATA_W    (DATA_W),
        .SRC_PORTS (SRC_PORTS)
    ) i_ren (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_tag     (a_map),
        .rd_valid   (r_valid),
        .rd_data    (r_data),
        .alloc_en   (alloc_en),
        .alloc_tag  (grant),
        .alloc_arch (dec_dst),
        .fin_en     (fin_valid),
        .fin_tag    (fin_tag),
        .fin_data   (fin_data),
        .cmp_en     (cmp_valid),
        .cmp_tag    (cmp_tag),
        .cmp_arch   (cmp_arch),
        .cmp_data   (cmp_data),
        .busy_vec   (busy_vec)
    );

    // Three-way source resolution, one copy per source
    for (genvar s = 0; s < SRC_PORTS; s++) begin : g_src
        src_origin_e origin;
        // Pick the origin of source s, then drive its outputs
        always_comb begin
            if (!a_busy[s])      origin = SRC_FROM_ARCH;
            else if (r_valid[s]) origin = SRC_FROM_RENAME;
            else                 origin = SRC_PENDING;
            opnd_ready[s] = (origin != SRC_PENDING);
            opnd_value[s] = (origin == SRC_FROM_RENAME) ? r_data[s] : a_data[s];
            opnd_tag[s]   = a_map[s];
        end
    end

    // R9
    full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&busy_vec) |-> !alloc_en);

    // R9
    stall_keeps_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_stall && !cmp_valid) |=> $stable(busy_vec));

endmodule

// File: tb/test_regrename_core.sv
module test_regrename_core;
    localparam int NA = 8;
    localparam int NR = 4;
    localparam int DW = 16;
    localparam int NS = 2;
    localparam int AW = $clog2(NA);
    localparam int TW = $clog2(NR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic [NS-1:0][AW-1:0] dec_src = '0;
    logic dec_wr = 1'b0;
    logic [AW-1:0] dec_dst = '0;
    logic dec_stall;
    logic [TW-1:0] dec_dst_tag;
    logic [NS-1:0] opnd_ready;
    logic [NS-1:0][DW-1:0] opnd_value;
    logic [NS-1:0][TW-1:0] opnd_tag;
    logic fin_valid = 1'b0;
    logic [TW-1:0] fin_tag = '0;
    logic [DW-1:0] fin_data = '0;
    logic cmp_valid = 1'b0;
    logic [TW-1:0] cmp_tag = '0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    regrename_core #(.ARCH_REGS(NA), .REN_REGS(NR), .DATA_W(DW), .SRC_PORTS(NS)) i_regrename_core (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src(dec_src),
        .dec_wr(dec_wr), .dec_dst(dec_dst), .dec_stall(dec_stall),
        .dec_dst_tag(dec_dst_tag), .opnd_ready(opnd_ready), .opnd_value(opnd_value),
        .opnd_tag(opnd_tag), .fin_valid(fin_valid), .fin_tag(fin_tag),
        .fin_data(fin_data), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        dec_valid = 1'b0; dec_wr = 1'b0; fin_valid = 1'b0; cmp_valid = 1'b0;
    endtask

    // Wait for the next edge and return at the following falling edge
    task automatic cyc();
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic srcs(input int a, input int b);
        dec_src[0] = AW'(a);
        dec_src[1] = AW'(b);
    endtask

    task automatic alloc(input int dst);
        dec_valid = 1'b1; dec_wr = 1'b1; dec_dst = AW'(dst);
    endtask

    task automatic t_reset();
        do_reset();
        srcs(3, 5);
        alloc(1);
        #2;
        check("R1 ready0", opnd_ready[0], 1); check("R1 ready1", opnd_ready[1], 1);
        check("R1 value", opnd_value[0], 0);
        check("R1 stall", dec_stall, 0); check("R1 first tag", dec_dst_tag, 0);
        cyc();
    endtask

    task automatic t_flow();
        do_reset();
        alloc(3); #2;
        check("R5 tag", dec_dst_tag, 0);
        cyc();
        srcs(3, 5); #2;
        check("R4 not ready", opnd_ready[0], 0);
        check("R4 tag", opnd_tag[0], 0);
        check("R2 other ready", opnd_ready[1], 1);
        fin_valid = 1'b1; fin_tag = 0; fin_data = 16'hAAAA; #1;
        check("R11 bypass ready", opnd_ready[0], 1);
        check("R11 bypass value", opnd_value[0], 16'hAAAA);
        cyc();
        srcs(3, 3); #2;
        check("R6/R3 ready", opnd_ready[0], 1);
        check("R3 value", opnd_value[1], 16'hAAAA);
        cmp_valid = 1'b1; cmp_tag = 0;
        cyc();
        srcs(3, 0); alloc(5); #2;
        check("R7 arch ready", opnd_ready[0], 1);
        check("R7 arch value", opnd_value[0], 16'hAAAA);
        check("R7 tag reused", dec_dst_tag, 0);
        cyc();
    endtask

    task automatic t_younger();
        do_reset();
        alloc(2); #2; check("R5 older tag", dec_dst_tag, 0); cyc();
        alloc(2); #2; check("R5 younger tag", dec_dst_tag, 1); cyc();
        fin_valid = 1'b1; fin_tag = 0; fin_data = 16'h1111; cyc();
        cmp_valid = 1'b1; cmp_tag = 0; cyc();
        srcs(2, 2); #2;
        check("R8 still pending", opnd_ready[0], 0);
        check("R8 younger tag", opnd_tag[0], 1);
        fin_valid = 1'b1; fin_tag = 1; fin_data = 16'h2222; cyc();
        cmp_valid = 1'b1; cmp_tag = 1; cyc();
        srcs(2, 2); #2;
        check("R8 cleared", opnd_ready[0], 1);
        check("R8 value", opnd_value[0], 16'h2222);
        cyc();
    endtask

    task automatic t_src_dst();
        do_reset();
        alloc(4); #2; cyc();
        fin_valid = 1'b1; fin_tag = 0; fin_data = 16'h0BEE; cyc();
        cmp_valid = 1'b1; cmp_tag = 0; cyc();
        srcs(4, 4); alloc(4); #2;
        check("R10 src sees old", opnd_ready[0], 1);
        check("R10 old value", opnd_value[1], 16'h0BEE);
        check("R10 dst tag", dec_dst_tag, 0);
        cyc();
        srcs(4, 4); #2;
        check("R10 after alloc", opnd_ready[0], 0);
        cyc();
    endtask

    task automatic t_stall();
        do_reset();
        for (int i = 0; i < NR; i++) begin
            alloc(i); #2;
            check("R5 fill tag", dec_dst_tag, i);
            check("R9 no stall", dec_stall, 0);
            cyc();
        end
        alloc(6); #2;
        check("R9 stall", dec_stall, 1);
        cyc();
        srcs(6, 1); #2;
        check("R9 no rename", opnd_ready[0], 1);
        fin_valid = 1'b1; fin_tag = 1; fin_data = 16'h0055; cyc();
        cmp_valid = 1'b1; cmp_tag = 1; cyc();
        srcs(6, 1); alloc(6); #2;
        check("R7 freed reuse", dec_dst_tag, 1);
        check("R7 stall gone", dec_stall, 0);
        check("R7 copy", opnd_value[1], 16'h0055);
        cyc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_flow();
        t_younger();
        t_src_dst();
        t_stall();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule